// File: doc/BRIEF.md
# Multi-Format On-Off Keyed Word Modulator

This block turns a stream of frame bits into a single on-off keyed line for a low-rate radio transmitter. Each word it sends is built from optional pieces around the data. An optional wake-up burst comes first. Then come a fixed alternating preamble, a silent header and the data symbols, optionally framed by a leading and a trailing '1'. A silent guard gap closes the word. The data symbols use one of four line codes: pulse width, Manchester, variable pulse width or pulse position.

All timing comes from one base element. The base element is a whole number of clocks per time unit (`UNIT_CLKS`, where one unit stands for 100 µs) multiplied by 1, 2, 4 or 8. The header, the guard gap and the wake-up window are also counted in these units.

A word starts with a one-cycle strobe that also captures all format selections for the whole word. The block pulls data bits through a request/valid handshake. It raises a one-cycle done pulse when the word, including its guard gap, is over.

Top module: `ook_line_encoder`

## Requirements
- R1: After reset and whenever no word is in progress, `line_out`, `busy`, `done` and `bit_req` are all low.
- R2: The base element lasts `UNIT_CLKS << rate_sel` clocks, so rate codes 0, 1, 2 and 3 give 1, 2, 4 and 8 units.
- R3: After the optional wake-up burst, a word sends 31 elements that alternate high and low, starting and ending high. It then holds the line low for a header of 4 elements (`hdr_long`=0) or 10 elements (`hdr_long`=1).
- R4: Line code 0 (pulse width) uses three elements per bit: a '1' is high, low, low and a '0' is high, high, low.
- R5: Line code 1 (Manchester) uses two elements per bit: a '0' is low then high and a '1' is high then low.
- R6: Line code 2 (variable width) sends each bit as one constant-level run. The level alternates from bit to bit, starting high at the first symbol after the header. A '0' lasts one element and a '1' lasts two.
- R7: Line code 3 (pulse position) uses three elements per bit with a single one-element high pulse: in the first element for a '0' and in the second for a '1'. The third element is low.
- R8: With `delim_en`=1, one '1' symbol in the selected line code is sent before the first data bit and one after the last.
- R9: After the last symbol the line is held low for a guard gap of 0, 64, 512 or 1024 units for `guard_sel` 0 to 3.
- R10: `wake_sel` 0 sends no wake-up burst. Codes 1, 2 and 3 open windows of 500, 750 and 1000 units. In these windows the burst repeats one high element followed by 2, 1 or 5 low elements respectively. Whole periods are sent until the window is covered, and the preamble follows at once.
- R11: `bit_req` is high during a word while no bit is held and the bit flagged `bit_last` has not yet been taken. Each cycle with `bit_req` and `bit_valid` both high hands over exactly one bit, and data bits go out in the order they were handed over.
- R12: `done` is high for one cycle, right after the last interval of the word. `busy` falls in that same cycle.
- R13: While a word is in progress, `start` and all format selections are ignored. The word keeps the settings captured at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that begins a word when idle |
| line_code | input | 2 | Line code: 0 pulse width, 1 Manchester, 2 variable width, 3 pulse position |
| rate_sel | input | 2 | Base element as 1, 2, 4 or 8 units |
| hdr_long | input | 1 | Header of 10 elements when high, 4 when low |
| guard_sel | input | 2 | Guard gap of 0, 64, 512 or 1024 units |
| wake_sel | input | 2 | Wake-up burst: none, 500, 750 or 1000 units |
| delim_en | input | 1 | Adds a '1' symbol before and after the data |
| bit_valid | input | 1 | A data bit is offered |
| bit_data | input | 1 | Value of the offered bit |
| bit_last | input | 1 | The offered bit is the last of the word |
| bit_req | output | 1 | The block can take a data bit |
| line_out | output | 1 | Keyed output line |
| busy | output | 1 | A word is in progress |
| done | output | 1 | One-cycle end-of-word pulse |

## Verification
Words are sent with every line code. Each uses a bit pattern with both long runs of equal bits and alternations, so that code-specific slot levels, the level alternation of the variable-width code and run merging across the silent header all show in the measured run lengths. The rate, header, guard and wake-up codes are spread across the words. This way a wrong element multiplier, header length, guard length or wake-up period count changes a specific run length. Framing bits are turned on for the Manchester and pulse-position words, where a missing or extra '1' shifts the run sequence. One word gets a second start strobe and changed format inputs while it is in progress, which separates a design that captures its settings from one that follows live inputs.

// File: rtl/ook_pkg.sv
package ook_pkg;

   typedef enum logic [1:0] {
      LC_PWM = 2'd0,
      LC_MAN = 2'd1,
      LC_VPW = 2'd2,
      LC_PPM = 2'd3
   } line_code_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAKE,
      ST_PRE,
      ST_HDR,
      ST_SYM,
      ST_STALL,
      ST_GUARD
   } seq_state_e;

   typedef enum logic [2:0] {
      NK_START,
      NK_DATA,
      NK_STOP,
      NK_STALL,
      NK_END
   } next_kind_e;

   typedef struct packed {
      line_code_e  code;
      logic [1:0]  rate;
      logic        hdr_long;
      logic [1:0]  guard;
      logic [1:0]  wake;
      logic        delim;
   } word_cfg_t;

   localparam int PRE_ELEMS  = 31;
   localparam int HDR_SHORT  = 4;
   localparam int HDR_LONG   = 10;
   localparam int MAX_UNITS  = 1024;

   function automatic int guard_units(input logic [1:0] sel);
      case (sel)
         2'd0:    return 0;
         2'd1:    return 64;
         2'd2:    return 512;
         default: return 1024;
      endcase
   endfunction

   function automatic int wake_units(input logic [1:0] sel);
      case (sel)
         2'd0:    return 0;
         2'd1:    return 500;
         2'd2:    return 750;
         default: return 1000;
      endcase
   endfunction

   function automatic int wake_low_elems(input logic [1:0] sel);
      case (sel)
         2'd1:    return 2;
         2'd2:    return 1;
         2'd3:    return 5;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/ook_time_base.sv
module ook_time_base
   import ook_pkg::*;
#(
   parameter int UNIT_CLKS = 4,
   parameter int TW        = 13
) (
   input  word_cfg_t       cfg,
   output logic [TW-1:0]   elem_len,
   output logic [TW-1:0]   hdr_len,
   output logic [TW-1:0]   guard_len,
   output logic [TW-1:0]   wake_len,
   output logic [TW-1:0]   wake_low_len
);

   logic [TW-1:0] unit_w;

   assign unit_w       = TW'(UNIT_CLKS);
   assign elem_len     = unit_w << cfg.rate;
   assign hdr_len      = (cfg.hdr_long ? TW'(HDR_LONG) : TW'(HDR_SHORT)) * elem_len;
   assign guard_len    = TW'(guard_units(cfg.guard) * UNIT_CLKS);
   assign wake_len     = TW'(wake_units(cfg.wake) * UNIT_CLKS);
   assign wake_low_len = TW'(wake_low_elems(cfg.wake)) * elem_len;

endmodule

// File: rtl/ook_symbol_map.sv
module ook_symbol_map
   import ook_pkg::*;
(
   input  line_code_e   code,
   input  logic         bit_v,
   input  logic [1:0]   slot,
   input  logic         vlev,
   output logic         lvl,
   output logic [1:0]   nel,
   output logic         last
);

   always_comb begin
      lvl  = 1'b0;
      nel  = 2'd1;
      last = 1'b0;
      unique case (code)
         LC_PWM: begin
            last = (slot == 2'd2);
            case (slot)
               2'd0:    lvl = 1'b1;
               2'd1:    lvl = ~bit_v;
               default: lvl = 1'b0;
            endcase
         end
         LC_MAN: begin
            last = (slot != 2'd0);
            lvl  = (slot == 2'd0) ? bit_v : ~bit_v;
         end
         LC_VPW: begin
            last = 1'b1;
            lvl  = vlev;
            nel  = bit_v ? 2'd2 : 2'd1;
         end
         default: begin
            last = (slot == 2'd2);
            case (slot)
               2'd0:    lvl = ~bit_v;
               2'd1:    lvl = bit_v;
               default: lvl = 1'b0;
            endcase
         end
      endcase
   end

endmodule

// File: rtl/ook_frame_seq.sv
module ook_frame_seq
   import ook_pkg::*;
#(
   parameter int UNIT_CLKS = 4,
   parameter int TW        = 13
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  word_cfg_t   cfg_in,
   input  logic        bit_valid,
   input  logic        bit_data,
   input  logic        bit_last,
   output logic        bit_req,
   output logic        line_out,
   output logic        busy,
   output logic        done
);

   localparam int PCW = $clog2(PRE_ELEMS + 1);

   seq_state_e     state;
   word_cfg_t      cfg_q, cfg_eff;
   logic [TW-1:0]  tmr, wtmr;
   logic [PCW-1:0] pcnt;
   logic [1:0]     slot;
   logic           line_q, done_q, vlev, cur_bit;
   logic           did_start, did_data, did_stop, got_last;
   logic           stage_v, stage_d, stage_last;

   logic [TW-1:0]  elem_len, hdr_len, guard_len, wake_len, wake_low_len;
   logic           cur_lvl, cur_last, lk_lvl, lk_last;
   logic [1:0]     cur_nel, lk_nel;
   next_kind_e     nk;
   logic           nb, boundary, adv_now, lk_bit, lk_vlev;
   logic [1:0]     lk_slot;
   logic [TW-1:0]  lk_len;
   logic           tmr_end;

   assign cfg_eff = (state == ST_IDLE) ? cfg_in : cfg_q;

   ook_time_base #(.UNIT_CLKS(UNIT_CLKS), .TW(TW)) u_time (
      .cfg          (cfg_eff),
      .elem_len     (elem_len),
      .hdr_len      (hdr_len),
      .guard_len    (guard_len),
      .wake_len     (wake_len),
      .wake_low_len (wake_low_len)
   );

   ook_symbol_map u_cur_map (
      .code  (cfg_q.code),
      .bit_v (cur_bit),
      .slot  (slot),
      .vlev  (vlev),
      .lvl   (cur_lvl),
      .nel   (cur_nel),
      .last  (cur_last)
   );

   ook_symbol_map u_next_map (
      .code  (cfg_q.code),
      .bit_v (lk_bit),
      .slot  (lk_slot),
      .vlev  (lk_vlev),
      .lvl   (lk_lvl),
      .nel   (lk_nel),
      .last  (lk_last)
   );

   // choice of the symbol that follows the current one
   always_comb begin
      nb = 1'b0;
      nk = NK_END;
      if (cfg_q.delim && !did_start) begin
         nk = NK_START;
         nb = 1'b1;
      end else if (!did_data) begin
         if (stage_v) begin
            nk = NK_DATA;
            nb = stage_d;
         end else begin
            nk = NK_STALL;
         end
      end else if (cfg_q.delim && !did_stop) begin
         nk = NK_STOP;
         nb = 1'b1;
      end
   end

   assign tmr_end  = (tmr == '0);
   assign boundary = (state == ST_HDR) || (state == ST_STALL) ||
                     ((state == ST_SYM) && cur_last);
   assign adv_now  = ((state == ST_HDR) && tmr_end) || (state == ST_STALL) ||
                     ((state == ST_SYM) && tmr_end && cur_last);
   assign lk_bit   = boundary ? nb : cur_bit;
   assign lk_slot  = boundary ? 2'd0 : slot + 2'd1;
   assign lk_vlev  = boundary ? ~vlev : vlev;
   assign lk_len   = (lk_nel == 2'd2) ? (elem_len << 1) : elem_len;

   assign bit_req  = (state != ST_IDLE) && !stage_v && !got_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cfg_q      <= '0;
         tmr        <= '0;
         wtmr       <= '0;
         pcnt       <= '0;
         slot       <= '0;
         line_q     <= 1'b0;
         done_q     <= 1'b0;
         vlev       <= 1'b0;
         cur_bit    <= 1'b0;
         did_start  <= 1'b0;
         did_data   <= 1'b0;
         did_stop   <= 1'b0;
         got_last   <= 1'b0;
         stage_v    <= 1'b0;
         stage_d    <= 1'b0;
         stage_last <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!tmr_end)      tmr  <= tmr - TW'(1);
         if (wtmr != '0)    wtmr <= wtmr - TW'(1);
         if (bit_req && bit_valid) begin
            stage_v    <= 1'b1;
            stage_d    <= bit_data;
            stage_last <= bit_last;
            got_last   <= bit_last;
         end

         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  cfg_q     <= cfg_in;
                  did_start <= 1'b0;
                  did_data  <= 1'b0;
                  did_stop  <= 1'b0;
                  got_last  <= 1'b0;
                  stage_v   <= 1'b0;
                  line_q    <= 1'b1;
                  tmr       <= elem_len - TW'(1);
                  slot      <= '0;
                  pcnt      <= '0;
                  wtmr      <= (cfg_in.wake != 2'd0) ? wake_len - TW'(1) : '0;
                  state     <= (cfg_in.wake != 2'd0) ? ST_WAKE : ST_PRE;
               end
            end
            ST_WAKE: begin
               if (tmr_end) begin
                  if (slot == 2'd0) begin
                     line_q <= 1'b0;
                     slot   <= 2'd1;
                     tmr    <= wake_low_len - TW'(1);
                  end else begin
                     line_q <= 1'b1;
                     slot   <= 2'd0;
                     tmr    <= elem_len - TW'(1);
                     if (wtmr == '0) begin
                        state <= ST_PRE;
                        pcnt  <= '0;
                     end
                  end
               end
            end
            ST_PRE: begin
               if (tmr_end) begin
                  if (pcnt == PCW'(PRE_ELEMS - 1)) begin
                     state  <= ST_HDR;
                     line_q <= 1'b0;
                     tmr    <= hdr_len - TW'(1);
                     vlev   <= 1'b0;
                  end else begin
                     pcnt   <= pcnt + PCW'(1);
                     line_q <= ~line_q;
                     tmr    <= elem_len - TW'(1);
                  end
               end
            end
            ST_SYM: begin
               if (tmr_end && !cur_last) begin
                  slot   <= slot + 2'd1;
                  line_q <= lk_lvl;
                  tmr    <= lk_len - TW'(1);
               end
            end
            ST_GUARD: begin
               if (tmr_end) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: ;
         endcase

         if (adv_now) begin
            if (nk == NK_STALL) begin
               state  <= ST_STALL;
               line_q <= 1'b0;
            end else if (nk == NK_END) begin
               line_q <= 1'b0;
               if (guard_len == '0) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  state <= ST_GUARD;
                  tmr   <= guard_len - TW'(1);
               end
            end else begin
               state   <= ST_SYM;
               cur_bit <= nb;
               slot    <= 2'd0;
               line_q  <= lk_lvl;
               tmr     <= lk_len - TW'(1);
               vlev    <= lk_vlev;
               if (nk == NK_START) did_start <= 1'b1;
               if (nk == NK_STOP)  did_stop  <= 1'b1;
               if (nk == NK_DATA) begin
                  stage_v  <= 1'b0;
                  did_data <= stage_last;
               end
            end
         end
      end
   end

   assign line_out = line_q;
   assign busy     = (state != ST_IDLE);
   assign done     = done_q;

endmodule

// File: rtl/ook_line_encoder.sv
module ook_line_encoder
   import ook_pkg::*;
#(
   parameter int UNIT_CLKS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] line_code,
   input  logic [1:0] rate_sel,
   input  logic       hdr_long,
   input  logic [1:0] guard_sel,
   input  logic [1:0] wake_sel,
   input  logic       delim_en,
   input  logic       bit_valid,
   input  logic       bit_data,
   input  logic       bit_last,
   output logic       bit_req,
   output logic       line_out,
   output logic       busy,
   output logic       done
);

   localparam int TW = $clog2(MAX_UNITS * UNIT_CLKS + 1);

   if (UNIT_CLKS < 2) begin : g_unit_too_small
      $error("UNIT_CLKS must be at least 2");
   end
   if (TW > 30) begin : g_timer_too_wide
      $error("UNIT_CLKS too large for the interval timer");
   end

   word_cfg_t cfg_in;

   assign cfg_in.code     = line_code_e'(line_code);
   assign cfg_in.rate     = rate_sel;
   assign cfg_in.hdr_long = hdr_long;
   assign cfg_in.guard    = guard_sel;
   assign cfg_in.wake     = wake_sel;
   assign cfg_in.delim    = delim_en;

   ook_frame_seq #(.UNIT_CLKS(UNIT_CLKS), .TW(TW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_in    (cfg_in),
      .bit_valid (bit_valid),
      .bit_data  (bit_data),
      .bit_last  (bit_last),
      .bit_req   (bit_req),
      .line_out  (line_out),
      .busy      (busy),
      .done      (done)
   );

endmodule

// File: rtl/ook_line_encoder_chk.sv
module ook_line_encoder_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_req,
   input logic line_out,
   input logic busy,
   input logic done
);

   // R1: line silent outside a word
   p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !line_out);

   // R11: bits are only requested inside a word
   p_req_in_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bit_req |-> busy);

   // R12: end pulse lasts one cycle
   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12: end pulse coincides with the fall of busy
   p_done_closes_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R3: every word opens with a high element
   p_word_opens_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> line_out);

endmodule

bind ook_line_encoder ook_line_encoder_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_req  (bit_req),
   .line_out (line_out),
   .busy     (busy),
   .done     (done)
);

// File: tb/test_ook_line_encoder.sv
module test_ook_line_encoder;

   localparam int U = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] line_code = 2'd0;
   logic [1:0] rate_sel = 2'd0;
   logic       hdr_long = 1'b0;
   logic [1:0] guard_sel = 2'd0;
   logic [1:0] wake_sel = 2'd0;
   logic       delim_en = 1'b0;
   logic       bit_valid = 1'b0;
   logic       bit_data = 1'b0;
   logic       bit_last = 1'b0;
   logic       bit_req, line_out, busy, done;

   always #10 clk = ~clk;

   ook_line_encoder #(.UNIT_CLKS(U)) i_ook_line_encoder (
      .clk(clk), .rst_n(rst_n), .start(start), .line_code(line_code),
      .rate_sel(rate_sel), .hdr_long(hdr_long), .guard_sel(guard_sel),
      .wake_sel(wake_sel), .delim_en(delim_en), .bit_valid(bit_valid),
      .bit_data(bit_data), .bit_last(bit_last), .bit_req(bit_req),
      .line_out(line_out), .busy(busy), .done(done)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int q_lvl[$];
   int q_len[$];
   string q_tag[$];
   int frames_done = 0;
   int f_n = 0, f_idx = 0;
   logic [31:0] f_bits = '0;
   bit extra_req = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push_run(input int lvl, input int len, input string tag);
      if (q_lvl.size() > 0 && q_lvl[$] == lvl) q_len[$] = q_len[$] + len;
      else begin
         q_lvl.push_back(lvl);
         q_len.push_back(len);
         q_tag.push_back(tag);
      end
   endtask

   task automatic close_run(input int lvl, input int len);
      if (q_lvl.size() == 0) begin
         check(1'b0, "R12", "unexpected run length", len, 0);
      end else begin
         int el, en;
         string et;
         el = q_lvl.pop_front();
         en = q_len.pop_front();
         et = q_tag.pop_front();
         check(el == lvl, et, "run level", lvl, el);
         check(en == len, et, "run length", len, en);
      end
   endtask

   // feeder: answers bit requests with the prepared bits
   initial begin
      forever begin
         @(negedge clk);
         if (bit_valid) bit_valid = 1'b0;
         else if (bit_req && f_idx < f_n) begin
            bit_valid = 1'b1;
            bit_data  = f_bits[f_idx];
            bit_last  = (f_idx == f_n - 1);
            f_idx++;
         end else if (bit_req && f_idx >= f_n) extra_req = 1'b1;
      end
   end

   // monitor: measures runs on the line and compares against the queue
   initial begin
      bit active = 1'b0;
      int cur = 0, cnt = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         if (!active) begin
            if (busy) begin
               active = 1'b1;
               cur = int'(line_out);
               cnt = 1;
            end
         end else if (done || !busy) begin
            close_run(cur, cnt);
            check(q_lvl.size() == 0, "R12", "runs left at end of word", q_lvl.size(), 0);
            check(done == 1'b1 && busy == 1'b0, "R12", "done with busy low", int'(done), 1);
            active = 1'b0;
            frames_done++;
         end else if (int'(line_out) != cur) begin
            close_run(cur, cnt);
            cur = int'(line_out);
            cnt = 1;
         end else cnt++;
      end
   end

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      check(1'b0, "R12", "watchdog expired", 0, 1);
      finish_run();
   end

   task automatic send_word(input logic [1:0] code, input logic [1:0] rate,
                            input bit hl, input logic [1:0] gs, input logic [1:0] ws,
                            input bit dl, input int nbits, input logic [31:0] bits,
                            input bit disturb);
      int e, prev, wait_cnt, vl;
      int syms[$];
      e = U << rate;
      // wake-up burst R10
      if (ws != 0) begin
         int d, k, p;
         d = (ws == 1) ? 500 : (ws == 2) ? 750 : 1000;
         k = (ws == 1) ? 2 : (ws == 2) ? 1 : 5;
         p = (d * U + (k + 1) * e - 1) / ((k + 1) * e);
         for (int i = 0; i < p; i++) begin
            push_run(1, e, "R10");
            push_run(0, k * e, "R10");
         end
      end
      // preamble and header R3 R2
      for (int i = 0; i < 31; i++) push_run((i % 2 == 0) ? 1 : 0, e, "R3 R2");
      push_run(0, (hl ? 10 : 4) * e, "R3");
      if (dl) syms.push_back(1);
      for (int i = 0; i < nbits; i++) syms.push_back(int'(bits[i]));
      if (dl) syms.push_back(1);
      vl = 1;
      foreach (syms[i]) begin
         int b;
         string tg;
         b = syms[i];
         if (dl && (i == 0 || i == syms.size() - 1)) tg = "R8";
         else tg = (code == 0) ? "R4" : (code == 1) ? "R5" : (code == 2) ? "R6" : "R7";
         case (code)
            2'd0: begin push_run(1, e, tg); push_run(b ? 0 : 1, e, tg); push_run(0, e, tg); end
            2'd1: begin push_run(b, e, tg); push_run(1 - b, e, tg); end
            2'd2: begin push_run(vl, b ? 2 * e : e, tg); vl = 1 - vl; end
            default: begin push_run(1 - b, e, tg); push_run(b, e, tg); push_run(0, e, tg); end
         endcase
      end
      // guard gap R9
      if (gs != 0) push_run(0, ((gs == 1) ? 64 : (gs == 2) ? 512 : 1024) * U, "R9");

      f_bits = bits;
      f_n = nbits;
      f_idx = 0;
      extra_req = 1'b0;
      @(negedge clk);
      line_code = code; rate_sel = rate; hdr_long = hl;
      guard_sel = gs; wake_sel = ws; delim_en = dl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      prev = frames_done;
      wait_cnt = 0;
      while (frames_done == prev && wait_cnt < 30000) begin
         @(negedge clk);
         wait_cnt++;
         if (disturb && wait_cnt == 150) begin
            // R13: new strobe and new selections mid-word
            start = 1'b1;
            line_code = ~code; rate_sel = ~rate; hdr_long = ~hl;
            guard_sel = ~gs; wake_sel = ~ws; delim_en = ~dl;
         end
         if (disturb && wait_cnt == 151) start = 1'b0;
      end
      check(frames_done != prev, "R12", "word finished", frames_done - prev, 1);
      check(f_idx == f_n, "R11", "bits taken", f_idx, f_n);
      check(!extra_req, "R11", "request after last bit", int'(extra_req), 0);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0 && line_out == 1'b0, "R1",
            "idle after word", int'({done, busy, line_out}), 0);
      check(bit_req == 1'b0, "R1", "no request when idle", int'(bit_req), 0);
      q_lvl.delete(); q_len.delete(); q_tag.delete();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(line_out == 1'b0 && busy == 1'b0 && done == 1'b0 && bit_req == 1'b0,
            "R1", "outputs in reset", int'({line_out, busy, done, bit_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(line_out == 1'b0 && busy == 1'b0 && done == 1'b0 && bit_req == 1'b0,
            "R1", "outputs after reset", int'({line_out, busy, done, bit_req}), 0);

      // R4 pulse width, rate 0, short header, no guard
      send_word(2'd0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 8, 32'hA5, 1'b0);
      // R5 R8 Manchester with framing bits, rate 1, long header, 64-unit guard
      send_word(2'd1, 2'd1, 1'b1, 2'd1, 2'd0, 1'b1, 6, 32'h0B, 1'b0);
      // R6 variable width, mixed runs of equal bits
      send_word(2'd2, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 7, 32'h0B, 1'b0);
      // R7 R8 R10 pulse position with framing, 750-unit wake-up, 512-unit guard
      send_word(2'd3, 2'd2, 1'b0, 2'd2, 2'd2, 1'b1, 5, 32'h16, 1'b0);
      // R2 R10 single bit at rate 3, 500-unit wake-up, 1024-unit guard
      send_word(2'd0, 2'd3, 1'b1, 2'd3, 2'd1, 1'b0, 1, 32'h1, 1'b0);
      // R10 R13 Manchester with 1000-unit wake-up, disturbed mid-word
      send_word(2'd1, 2'd0, 1'b0, 2'd1, 2'd3, 1'b0, 10, 32'h2C7, 1'b1);
      // R6 R8 variable width with framing, all ones
      send_word(2'd2, 2'd1, 1'b1, 2'd0, 2'd0, 1'b1, 4, 32'hF, 1'b0);

      finish_run();
   end

endmodule